// File: doc/BRIEF.md
# Thrash Detection and Recovery Controller

This controller guards polled remote memory accesses against losing their reply data between the moment the reply arrives and the moment the requesting context consumes it. Each hardware context owns a small number of transaction slots, and every slot has one tried-once bit. The first miss on an access sets the bit. A later miss on the same slot with its bit already set, while the transaction status reports completion, means the reply came back and was lost again. The controller treats that as thrashing.

On thrashing the controller starts recovery. It pulses a retry request that carries the context and slot numbers. It then spin-waits for the reply, holding context switching disabled and holding a processor-wide lock that defers every external invalidation. Interrupts may still be taken during the spin. A reply that arrives while an interrupt handler runs is held back until the handler exits, and the lock stays up for that whole time. The transaction buffer and the interrupt handlers are outside this block.

Top module: `thrash_recovery_ctl`

## Requirements
- R1: After reset, `csDisable`, `invDefer` and `retryReq` are 0 and `triedMask` is all zeros.
- R2: When no recovery is running, a missed access (`accValid`=1, `accHit`=0) to a slot whose tried bit is clear sets that bit. The bit is at position `accCtx*NUM_SLOT+accSlot` of `triedMask` and is visible in the next cycle.
- R3: A hitting access clears the slot's tried bit. A `freeValid` pulse clears the tried bit of `freeCtx`/`freeSlot`. When an access and a free target the same bit in the same cycle, the access update wins.
- R4: A missed access to a slot whose tried bit is set, with `txnDone`=1, is thrashing. In the next cycle `retryReq` is high for exactly one cycle, with `retryCtx`/`retrySlot` equal to that access. The same miss with `txnDone`=0 changes nothing.
- R5: From the cycle after detection, and for as long as recovery spins, `csDisable` and `invDefer` are both 1.
- R6: If `dataArrive` is seen during the spin while no interrupt is active, `csDisable` and `invDefer` both fall to 0 in the next cycle.
- R7: If an interrupt is active when `dataArrive` is seen, both outputs stay at 1 until the cycle after `irqExit`, and then both fall together.
- R8: One cycle after the lock falls, the tried bit of the recovered slot reads 0.
- R9: During recovery, access attempts leave `triedMask` unchanged and cannot start a new recovery, and `retryCtx`/`retrySlot` stay fixed.
- R10: Interrupt state follows `irqEnter`/`irqExit` in every state, so an interrupt entered before thrashing still holds back completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | A context attempts an access this cycle |
| accCtx | input | CTX_W | Context making the attempt |
| accSlot | input | SLOT_W | Transaction slot of the attempt |
| accHit | input | 1 | The attempt found its data |
| txnDone | input | 1 | Buffer status shows the slot's transaction complete |
| freeValid | input | 1 | A transaction slot is released |
| freeCtx | input | CTX_W | Context of the released slot |
| freeSlot | input | SLOT_W | Released slot |
| dataArrive | input | 1 | Reply for the reissued access is present |
| irqEnter | input | 1 | Interrupt handler entry pulse |
| irqExit | input | 1 | Interrupt handler exit pulse |
| csDisable | output | 1 | Context switching disabled |
| invDefer | output | 1 | External invalidations deferred |
| retryReq | output | 1 | One-cycle request to reissue the access |
| retryCtx | output | CTX_W | Context being recovered |
| retrySlot | output | SLOT_W | Slot being recovered |
| triedMask | output | NUM_CTX*NUM_SLOT | Tried-once bits |

## Verification
The hardest case to reach is a reply that lands while an interrupt handler is running inside the spin-wait. To get there, the stimulus first drives two misses on one slot, with the transaction status set to complete on the second, to start recovery. It then enters an interrupt before pulsing the reply and keeps the handler open for several cycles, so the bench can confirm the lock holds until exit. A second pass enters the interrupt while the controller is still idle, before the thrashing miss, so that the interrupt state carried across the start of recovery is exercised as well.

// File: rtl/thrash_pkg.sv
package thrash_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SPIN = 2'd1, ST_DONE = 2'd2} recState_t;

  typedef struct packed {
    logic setTried;
    logic clrTried;
    logic clrRecov;
    logic latchIdx;
  } dpStrobe_t;
endpackage

// File: rtl/thrash_dp.sv
module thrash_dp
  import thrash_pkg::*;
#(
  parameter int NUM_CTX  = 4,
  parameter int NUM_SLOT = 2,
  localparam int CTX_W  = (NUM_CTX  > 1) ? $clog2(NUM_CTX)  : 1,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int TOT    = NUM_CTX * NUM_SLOT,
  localparam int IDX_W  = (TOT > 1) ? $clog2(TOT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [CTX_W-1:0]  accCtx,
  input  logic [SLOT_W-1:0] accSlot,
  input  logic              freeValid,
  input  logic [CTX_W-1:0]  freeCtx,
  input  logic [SLOT_W-1:0] freeSlot,
  input  logic              irqEnter,
  input  logic              irqExit,
  output logic              accTried,
  output logic              inIrq,
  output logic [CTX_W-1:0]  recCtx,
  output logic [SLOT_W-1:0] recSlot,
  output logic [TOT-1:0]    triedMask
);
  function automatic logic [IDX_W-1:0] idxOf(input logic [CTX_W-1:0] c, input logic [SLOT_W-1:0] s);
    return IDX_W'(IDX_W'(c) * IDX_W'(NUM_SLOT) + IDX_W'(s));
  endfunction

  logic [IDX_W-1:0] accIdx, freeIdx, recIdx;
  logic [TOT-1:0]   triedQ;

  assign accIdx  = idxOf(accCtx, accSlot);
  assign freeIdx = idxOf(freeCtx, freeSlot);
  assign recIdx  = idxOf(recCtx, recSlot);

  for (genvar g = 0; g < TOT; g++) begin : g_tried
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          triedQ[g] <= 1'b0;
      else if (strb.setTried && accIdx == IDX_W'(g))      triedQ[g] <= 1'b1;
      else if (strb.clrTried && accIdx == IDX_W'(g))      triedQ[g] <= 1'b0;
      else if (strb.clrRecov && recIdx == IDX_W'(g))      triedQ[g] <= 1'b0;
      else if (freeValid && freeIdx == IDX_W'(g))         triedQ[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCtx  <= '0;
      recSlot <= '0;
    end else if (strb.latchIdx) begin
      recCtx  <= accCtx;
      recSlot <= accSlot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         inIrq <= 1'b0;
    else if (irqEnter) inIrq <= 1'b1;
    else if (irqExit)  inIrq <= 1'b0;
  end

  assign accTried  = triedQ[accIdx];
  assign triedMask = triedQ;
endmodule

// File: rtl/thrash_ctl.sv
module thrash_ctl
  import thrash_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic       accHit,
  input  logic       txnDone,
  input  logic       accTried,
  input  logic       dataArrive,
  input  logic       inIrq,
  input  logic       irqExit,
  output dpStrobe_t  strb,
  output recState_t  state,
  output logic       retryReq
);
  recState_t stateQ, stateD;
  logic      heldQ, heldD;
  logic      arrived;

  assign arrived = dataArrive | heldQ;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    heldD  = heldQ;
    unique case (stateQ)
      ST_IDLE: begin
        heldD = 1'b0;
        if (accValid) begin
          if (accHit)         strb.clrTried = 1'b1;
          else if (!accTried) strb.setTried = 1'b1;
          else if (txnDone) begin
            strb.latchIdx = 1'b1;
            stateD        = ST_SPIN;
          end
        end
      end
      ST_SPIN: begin
        if (arrived && (!inIrq || irqExit)) begin
          stateD = ST_DONE;
          heldD  = 1'b0;
        end else if (arrived) begin
          heldD = 1'b1;
        end
      end
      ST_DONE: begin
        strb.clrRecov = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      heldQ    <= 1'b0;
      retryReq <= 1'b0;
    end else begin
      stateQ   <= stateD;
      heldQ    <= heldD;
      retryReq <= (stateQ == ST_IDLE) && (stateD == ST_SPIN);
    end
  end

  assign state = stateQ;
endmodule

// File: rtl/thrash_recovery_ctl.sv
module thrash_recovery_ctl
  import thrash_pkg::*;
#(
  parameter int NUM_CTX  = 4,
  parameter int NUM_SLOT = 2,
  localparam int CTX_W  = (NUM_CTX  > 1) ? $clog2(NUM_CTX)  : 1,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int TOT    = NUM_CTX * NUM_SLOT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [CTX_W-1:0]  accCtx,
  input  logic [SLOT_W-1:0] accSlot,
  input  logic              accHit,
  input  logic              txnDone,
  input  logic              freeValid,
  input  logic [CTX_W-1:0]  freeCtx,
  input  logic [SLOT_W-1:0] freeSlot,
  input  logic              dataArrive,
  input  logic              irqEnter,
  input  logic              irqExit,
  output logic              csDisable,
  output logic              invDefer,
  output logic              retryReq,
  output logic [CTX_W-1:0]  retryCtx,
  output logic [SLOT_W-1:0] retrySlot,
  output logic [TOT-1:0]    triedMask
);
  dpStrobe_t strb;
  recState_t state;
  logic      accTried, inIrq;

  thrash_ctl u_ctl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit), .txnDone(txnDone),
    .accTried(accTried), .dataArrive(dataArrive), .inIrq(inIrq), .irqExit(irqExit),
    .strb(strb), .state(state), .retryReq(retryReq)
  );

  thrash_dp #(.NUM_CTX(NUM_CTX), .NUM_SLOT(NUM_SLOT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accCtx(accCtx), .accSlot(accSlot),
    .freeValid(freeValid), .freeCtx(freeCtx), .freeSlot(freeSlot),
    .irqEnter(irqEnter), .irqExit(irqExit), .accTried(accTried), .inIrq(inIrq),
    .recCtx(retryCtx), .recSlot(retrySlot), .triedMask(triedMask)
  );

  assign csDisable = (state == ST_SPIN);
  assign invDefer  = (state == ST_SPIN);
endmodule

// File: rtl/thrash_recovery_chk.sv
module thrash_recovery_chk #(
  parameter int NUM_CTX  = 4,
  parameter int NUM_SLOT = 2,
  localparam int CTX_W  = (NUM_CTX  > 1) ? $clog2(NUM_CTX)  : 1,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int TOT    = NUM_CTX * NUM_SLOT
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              irqEnter,
  input logic              irqExit,
  input logic              csDisable,
  input logic              invDefer,
  input logic              retryReq,
  input logic [CTX_W-1:0]  retryCtx,
  input logic [SLOT_W-1:0] retrySlot,
  input logic [TOT-1:0]    triedMask
);
  logic irqBusy;
  int   recIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irqBusy <= 1'b0;
    else if (irqEnter) irqBusy <= 1'b1;
    else if (irqExit)  irqBusy <= 1'b0;
  end

  assign recIdx = int'(retryCtx) * NUM_SLOT + int'(retrySlot);

  AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |=> !retryReq); // R4
  AST_RETRY_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |-> (invDefer && csDisable)); // R5
  AST_LOCK_FALL_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(invDefer) |-> $fell(csDisable)); // R6
  AST_HOLD_IN_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (invDefer && irqBusy && !irqExit) |=> invDefer); // R7
  AST_RECOVER_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(invDefer) |=> !triedMask[recIdx]); // R8
  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    invDefer |=> (!invDefer || ($stable(retryCtx) && $stable(retrySlot)))); // R9
endmodule

bind thrash_recovery_ctl thrash_recovery_chk #(.NUM_CTX(NUM_CTX), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .irqEnter(irqEnter), .irqExit(irqExit),
  .csDisable(csDisable), .invDefer(invDefer), .retryReq(retryReq),
  .retryCtx(retryCtx), .retrySlot(retrySlot), .triedMask(triedMask)
);

// File: tb/thrash_recovery_ctl_tb.sv
`timescale 1ns/1ps
module thrash_recovery_ctl_tb;
  localparam int NC = 4;
  localparam int NS = 2;
  localparam int TOT = NC * NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 0, accHit = 0, txnDone = 0, freeValid = 0, dataArrive = 0, irqEnter = 0, irqExit = 0;
  logic [1:0] accCtx = 0, freeCtx = 0;
  logic [0:0] accSlot = 0, freeSlot = 0;
  logic csDisable, invDefer, retryReq;
  logic [1:0] retryCtx;
  logic [0:0] retrySlot;
  logic [TOT-1:0] triedMask;

  int checks = 0, fails = 0;
  int mState = 0, mCtx = 0, mSlot = 0;
  bit mIrq = 0, mHeld = 0, mRetry = 0;
  logic [TOT-1:0] mTried = '0;

  always #2 clk = ~clk;

  thrash_recovery_ctl #(.NUM_CTX(NC), .NUM_SLOT(NS)) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accCtx(accCtx), .accSlot(accSlot),
    .accHit(accHit), .txnDone(txnDone), .freeValid(freeValid), .freeCtx(freeCtx),
    .freeSlot(freeSlot), .dataArrive(dataArrive), .irqEnter(irqEnter), .irqExit(irqExit),
    .csDisable(csDisable), .invDefer(invDefer), .retryReq(retryReq), .retryCtx(retryCtx),
    .retrySlot(retrySlot), .triedMask(triedMask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: advances on each clock with the inputs the bench applied
  task automatic modelStep();
    int nState = mState;
    bit nHeld = mHeld, nIrq = mIrq, nRetry = 0;
    int nCtx = mCtx, nSlot = mSlot;
    logic [TOT-1:0] nTried = mTried;
    int a = accCtx * NS + accSlot;
    if (freeValid) nTried[freeCtx * NS + freeSlot] = 1'b0;
    if (mState == 2) begin
      nTried[mCtx * NS + mSlot] = 1'b0;
      nState = 0;
    end
    if (mState == 0 && accValid) begin
      if (accHit) nTried[a] = 1'b0;
      else if (!mTried[a]) nTried[a] = 1'b1;
      else if (txnDone) begin
        nState = 1; nRetry = 1; nCtx = accCtx; nSlot = accSlot; nHeld = 0;
      end
    end
    if (mState == 1) begin
      if ((dataArrive || mHeld) && (!mIrq || irqExit)) begin nState = 2; nHeld = 0; end
      else if (dataArrive || mHeld) nHeld = 1;
    end
    if (irqEnter) nIrq = 1; else if (irqExit) nIrq = 0;
    mState = nState; mHeld = nHeld; mIrq = nIrq; mRetry = nRetry;
    mCtx = nCtx; mSlot = nSlot; mTried = nTried;
  endtask

  task automatic compareAll();
    chk(csDisable == (mState == 1), "R5/R6/R7 csDisable", csDisable, mState == 1);
    chk(invDefer == (mState == 1), "R5/R6/R7 invDefer", invDefer, mState == 1);
    chk(retryReq == mRetry, "R4 retryReq", retryReq, mRetry);
    chk(triedMask == mTried, "R2/R3/R8/R9 triedMask", triedMask, mTried);
    if (mState != 0)
      chk(retryCtx == mCtx[1:0] && retrySlot == mSlot[0:0], "R4/R9 retry target",
          {retryCtx, retrySlot}, mCtx * 2 + mSlot);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    #1;
    compareAll();
    accValid = 0; accHit = 0; txnDone = 0; freeValid = 0;
    dataArrive = 0; irqEnter = 0; irqExit = 0;
  endtask

  task automatic access(input int c, input int s, input bit hit, input bit done);
    accValid = 1; accCtx = c[1:0]; accSlot = s[0:0]; accHit = hit; txnDone = done;
    cyc();
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk(csDisable == 0 && invDefer == 0 && retryReq == 0, "R1 outputs after reset",
        {csDisable, invDefer, retryReq}, 0);
    chk(triedMask == '0, "R1 triedMask after reset", triedMask, 0);
    rstN = 1'b1;
    cyc();

    // R2: first misses set bits 2 and 7
    access(1, 0, 0, 0);
    chk(triedMask[2] == 1, "R2 bit ctx1 slot0", triedMask[2], 1);
    access(3, 1, 0, 0);
    chk(triedMask[7] == 1, "R2 bit ctx3 slot1", triedMask[7], 1);

    // R4: repeated miss without completion does nothing
    access(1, 0, 0, 0);
    chk(csDisable == 0 && retryReq == 0, "R4 no thrash when txnDone=0", csDisable, 0);

    // R3: hit clears, free clears, access beats free
    access(1, 0, 1, 0);
    chk(triedMask[2] == 0, "R3 hit clears", triedMask[2], 0);
    freeValid = 1; freeCtx = 3; freeSlot = 1;
    cyc();
    chk(triedMask[7] == 0, "R3 free clears", triedMask[7], 0);
    freeValid = 1; freeCtx = 2; freeSlot = 0;
    access(2, 0, 0, 0);
    chk(triedMask[4] == 1, "R3 access wins over free", triedMask[4], 1);

    // R4/R5: thrash on ctx2 slot0
    access(2, 0, 0, 1);
    chk(retryReq == 1 && retryCtx == 2 && retrySlot == 0, "R4 retry pulse", retryReq, 1);
    chk(csDisable && invDefer, "R5 locks up", {csDisable, invDefer}, 3);
    cyc();
    chk(retryReq == 0, "R4 single pulse", retryReq, 0);
    // R9: access during spin ignored
    access(0, 0, 0, 0);
    chk(triedMask[0] == 0, "R9 access ignored in spin", triedMask[0], 0);
    access(2, 0, 0, 1);
    chk(retryReq == 0, "R9 no new recovery in spin", retryReq, 0);
    // R6: reply with no interrupt
    dataArrive = 1;
    cyc();
    chk(!csDisable && !invDefer, "R6 locks drop together", {csDisable, invDefer}, 0);
    cyc();
    chk(triedMask[4] == 0, "R8 recovered bit cleared", triedMask[4], 0);

    // R7: interrupt inside the spin
    access(0, 1, 0, 0);
    access(0, 1, 0, 1);
    irqEnter = 1; cyc();
    dataArrive = 1; cyc();
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(csDisable && invDefer, "R7 held during irq", {csDisable, invDefer}, 3);
    end
    irqExit = 1; cyc();
    chk(!csDisable && !invDefer, "R7 drop after irq exit", {csDisable, invDefer}, 0);
    cyc();
    chk(triedMask[1] == 0, "R8 bit cleared after irq", triedMask[1], 0);

    // R10: interrupt entered while idle, before thrashing
    irqEnter = 1; cyc();
    access(3, 0, 0, 0);
    access(3, 0, 0, 1);
    dataArrive = 1; cyc();
    repeat (2) begin
      cyc();
      chk(invDefer == 1, "R10 earlier irq holds completion", invDefer, 1);
    end
    irqExit = 1; dataArrive = 1; cyc();
    chk(invDefer == 0, "R10 release on exit", invDefer, 0);
    repeat (3) cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule